// File: doc/BRIEF.md
# Comparator Edge Event Capture

This block is the digital side of a low-power analog comparator. The raw comparator output arrives with no relation to the system clock. A short synchronizer chain brings it into the clock domain, and the synchronized level is readable as a status bit. The block detects transitions of that level in one selected direction, either rising or falling. A qualifying transition sets a sticky event flag, which software clears by writing to the register port.

The block drives three outputs from the flag and the level:

- `evtPulse`, a one-cycle event pulse for the event fabric.
- `wakeReq`, a level that requests wake from standby.
- `pinOut`, a copy of the comparator level for a device pin.

Each of these has its own enable bit. A module enable bit gates all of them.

The same configuration word also holds three analog selection codes: the positive input select, the negative input select and the hysteresis level. The block stores these codes and drives them unchanged to the analog macro.

Software reads the configuration word at any time on `regRdData`, and writes it whole with a one-cycle write strobe.

Top module: `cmpEvtCapture`

## Requirements
- R1: After reset, every writable bit of `regRdData` is 0, and `evtPulse`, `wakeReq` and `pinOut` are low.
- R2: Bit 20 of `regRdData` shows the comparator level after SYNC_STAGES clock edges, and is not yet changed after SYNC_STAGES-1 edges.
- R3: Bit 16 selects the qualifying edge: 0 for rising, 1 for falling. A synchronized edge of the selected direction sets the event flag (bit 24). An edge of the other direction leaves the flag unchanged.
- R4: The event flag is sticky. A write with bit 24 = 0 clears it, and a write with bit 24 = 1 sets it.
- R5: When a qualifying edge arrives in the same cycle as a write that clears the flag, the flag ends up set.
- R6: While the module enable (bit 0) is 0, no edges are detected, and `evtPulse` and `wakeReq` stay low.
- R7: `evtPulse` is high for exactly one cycle each time the AND of the flag, the event enable (bit 17) and the module enable changes from 0 to 1.
- R8: `wakeReq` equals the AND of the module enable, the wake enable (bit 18) and the flag.
- R9: `pinOut` equals the AND of the module enable, the pin enable (bit 21) and the synchronized level.
- R10: The hysteresis code (bits 7:5), positive select (bits 11:8) and negative select (bits 14:12) appear unchanged on `hystSel`, `posSel` and `negSel` and read back in place. All unlisted bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmpRawIn | input | 1 | Raw comparator output, asynchronous to clk |
| regWrEn | input | 1 | Write strobe for the configuration word |
| regWrData | input | 32 | Configuration word to write |
| regRdData | output | 32 | Current configuration, flag and level |
| evtPulse | output | 1 | One-cycle event to the fabric |
| wakeReq | output | 1 | Standby wake request level |
| pinOut | output | 1 | Comparator level for the device pin |
| posSel | output | 4 | Positive input selection code |
| negSel | output | 3 | Negative input selection code |
| hystSel | output | 3 | Hysteresis level code |

## Verification
The bench builds the block with its default parameters: a two-stage synchronizer and 4/3/3-bit selection codes.

With that small configuration, the bench sweeps all 32 combinations of the five mode bits against both edge directions, and checks the flag, pulse count, wake level and pin level of each combination from a formula. It also walks all 1024 pass-through code combinations.

Separate steps check the synchronizer latency edge by edge, and place a flag-clearing write on the exact cycle a qualifying edge is detected.

// File: rtl/cmpEvtPkg.sv
package cmpEvtPkg;
  localparam int EN_BIT    = 0;
  localparam int EDGE_BIT  = 16;
  localparam int EVTEN_BIT = 17;
  localparam int WAKE_BIT  = 18;
  localparam int LEVEL_BIT = 20;
  localparam int PIN_BIT   = 21;
  localparam int FLAG_BIT  = 24;

  // control -> datapath strobes
  typedef struct packed {
    logic detectEn;
    logic fallSel;
  } detCtrl_t;

  // datapath -> control results
  typedef struct packed {
    logic edgeHit;
    logic level;
  } detStat_t;
endpackage

// File: rtl/cmpEvtDetect.sv
module cmpEvtDetect
  import cmpEvtPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     rawIn,
  input  detCtrl_t ctrl,
  output detStat_t stat
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic levelPrev;
  logic level;
  logic riseSeen;
  logic fallSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ[0] <= 1'b0;
    else       syncQ[0] <= rawIn;
  end

  for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ[i] <= 1'b0;
      else       syncQ[i] <= syncQ[i-1];
    end
  end

  assign level = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) levelPrev <= 1'b0;
    else       levelPrev <= level;
  end

  assign riseSeen     = level & ~levelPrev;
  assign fallSeen     = ~level & levelPrev;
  assign stat.level   = level;
  assign stat.edgeHit = ctrl.detectEn & (ctrl.fallSel ? fallSeen : riseSeen);

  // R3
  edge_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    stat.edgeHit |-> (stat.level != $past(stat.level)));
  // R3
  edge_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    stat.edgeHit |-> (stat.level == !ctrl.fallSel));
endmodule

// File: rtl/cmpEvtCtrl.sv
module cmpEvtCtrl
  import cmpEvtPkg::*;
#(
  parameter int REG_W  = 32,
  parameter int HYST_W = 3,
  parameter int POS_W  = 4,
  parameter int NEG_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  detStat_t          stat,
  output detCtrl_t          ctrl,
  output logic              evtPulse,
  output logic              wakeReq,
  output logic              pinOut,
  output logic [POS_W-1:0]  posSel,
  output logic [NEG_W-1:0]  negSel,
  output logic [HYST_W-1:0] hystSel
);
  localparam int HYST_LSB = 5;
  localparam int POS_LSB  = HYST_LSB + HYST_W;
  localparam int NEG_LSB  = POS_LSB + POS_W;

  logic modEn, fallSel, evtEn, wakeEn, pinEn, evtFlag;
  logic gated, gatedQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modEn   <= 1'b0;
      fallSel <= 1'b0;
      evtEn   <= 1'b0;
      wakeEn  <= 1'b0;
      pinEn   <= 1'b0;
      posSel  <= '0;
      negSel  <= '0;
      hystSel <= '0;
    end else if (regWrEn) begin
      modEn   <= regWrData[EN_BIT];
      fallSel <= regWrData[EDGE_BIT];
      evtEn   <= regWrData[EVTEN_BIT];
      wakeEn  <= regWrData[WAKE_BIT];
      pinEn   <= regWrData[PIN_BIT];
      posSel  <= regWrData[POS_LSB +: POS_W];
      negSel  <= regWrData[NEG_LSB +: NEG_W];
      hystSel <= regWrData[HYST_LSB +: HYST_W];
    end
  end

  // hardware set has priority over a software write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             evtFlag <= 1'b0;
    else if (stat.edgeHit) evtFlag <= 1'b1;
    else if (regWrEn)      evtFlag <= regWrData[FLAG_BIT];
  end

  assign gated = evtFlag & evtEn & modEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) gatedQ <= 1'b0;
    else       gatedQ <= gated;
  end

  assign evtPulse     = gated & ~gatedQ;
  assign wakeReq      = modEn & wakeEn & evtFlag;
  assign pinOut       = modEn & pinEn & stat.level;
  assign ctrl.detectEn = modEn;
  assign ctrl.fallSel  = fallSel;

  always_comb begin
    regRdData = '0;
    regRdData[EN_BIT]    = modEn;
    regRdData[EDGE_BIT]  = fallSel;
    regRdData[EVTEN_BIT] = evtEn;
    regRdData[WAKE_BIT]  = wakeEn;
    regRdData[LEVEL_BIT] = stat.level;
    regRdData[PIN_BIT]   = pinEn;
    regRdData[FLAG_BIT]  = evtFlag;
    regRdData[POS_LSB +: POS_W]   = posSel;
    regRdData[NEG_LSB +: NEG_W]   = negSel;
    regRdData[HYST_LSB +: HYST_W] = hystSel;
  end

  // R3
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    stat.edgeHit |=> evtFlag);
  // R4
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !regWrData[FLAG_BIT] && !stat.edgeHit) |=> !evtFlag);
  // R4
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtFlag && !regWrEn) |=> evtFlag);
  // R6
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !modEn |-> (!evtPulse && !wakeReq));
  // R7
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtPulse |=> !evtPulse);
endmodule

// File: rtl/cmpEvtCapture.sv
module cmpEvtCapture
  import cmpEvtPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int REG_W       = 32,
  parameter int HYST_W      = 3,
  parameter int POS_W       = 4,
  parameter int NEG_W       = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmpRawIn,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  output logic              evtPulse,
  output logic              wakeReq,
  output logic              pinOut,
  output logic [POS_W-1:0]  posSel,
  output logic [NEG_W-1:0]  negSel,
  output logic [HYST_W-1:0] hystSel
);
  detCtrl_t detCtrl;
  detStat_t detStat;

  cmpEvtDetect #(.SYNC_STAGES(SYNC_STAGES)) u_detect (
    .clk   (clk),
    .rstN  (rstN),
    .rawIn (cmpRawIn),
    .ctrl  (detCtrl),
    .stat  (detStat)
  );

  cmpEvtCtrl #(.REG_W(REG_W), .HYST_W(HYST_W), .POS_W(POS_W), .NEG_W(NEG_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .stat      (detStat),
    .ctrl      (detCtrl),
    .evtPulse  (evtPulse),
    .wakeReq   (wakeReq),
    .pinOut    (pinOut),
    .posSel    (posSel),
    .negSel    (negSel),
    .hystSel   (hystSel)
  );
endmodule

// File: tb/cmpEvtCapture_tb.sv
`timescale 1ns/1ps
module cmpEvtCapture_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmpRawIn = 1'b0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        evtPulse, wakeReq, pinOut;
  logic [3:0]  posSel;
  logic [2:0]  negSel, hystSel;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  cmpEvtCapture u_dut (
    .clk(clk), .rstN(rstN), .cmpRawIn(cmpRawIn), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .evtPulse(evtPulse),
    .wakeReq(wakeReq), .pinOut(pinOut), .posSel(posSel), .negSel(negSel),
    .hystSel(hystSel)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wrCfg(input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1;
    regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  function automatic logic [31:0] mkCfg(input logic en, input logic fall, input logic ev,
                                        input logic wk, input logic pin, input logic flg);
    logic [31:0] d;
    d = '0;
    d[0] = en; d[16] = fall; d[17] = ev; d[18] = wk; d[21] = pin; d[24] = flg;
    return d;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(regRdData == 32'h0, "R1 readback", regRdData, 0);
    check({evtPulse, wakeReq, pinOut} == 3'b000, "R1 outputs", {evtPulse, wakeReq, pinOut}, 0);

    // R2 synchronizer latency
    cmpRawIn = 1'b1;
    @(negedge clk);
    check(regRdData[20] == 1'b0, "R2 level early", regRdData[20], 0);
    @(negedge clk);
    check(regRdData[20] == 1'b1, "R2 level due", regRdData[20], 1);
    cmpRawIn = 1'b0;
    @(negedge clk);
    check(regRdData[20] == 1'b1, "R2 fall early", regRdData[20], 1);
    @(negedge clk);
    check(regRdData[20] == 1'b0, "R2 fall due", regRdData[20], 0);

    // sweep of mode bits x edge direction: R3 R6 R7 R8 R9
    for (int m = 0; m < 32; m++) begin
      for (int dir = 0; dir < 2; dir++) begin
        logic en, fall, ev, wk, pin, startLvl, endLvl, expFlag;
        int pulses;
        en = m[0]; fall = m[1]; ev = m[2]; wk = m[3]; pin = m[4];
        startLvl = (dir == 1);
        endLvl = ~startLvl;
        cmpRawIn = startLvl;
        repeat (4) @(negedge clk);
        wrCfg(mkCfg(en, fall, ev, wk, pin, 1'b0));
        cmpRawIn = endLvl;
        pulses = 0;
        for (int c = 0; c < 6; c++) begin
          @(negedge clk);
          if (evtPulse) pulses++;
          if (!en) check(!evtPulse && !wakeReq, "R6 quiet while disabled", {evtPulse, wakeReq}, 0);
        end
        expFlag = en && (fall ? (dir == 1) : (dir == 0));
        check(regRdData[24] == expFlag, "R3 flag", regRdData[24], expFlag);
        check(pulses == int'(expFlag && ev), "R7 pulse count", pulses, int'(expFlag && ev));
        check(wakeReq == (en && wk && expFlag), "R8 wake", wakeReq, en && wk && expFlag);
        check(pinOut == (en && pin && endLvl), "R9 pin", pinOut, en && pin && endLvl);
      end
    end

    // R4 sticky, clear and software set
    wrCfg(mkCfg(1, 0, 1, 1, 0, 1));
    @(negedge clk);
    check(regRdData[24] == 1'b1, "R4 software set", regRdData[24], 1);
    repeat (5) @(negedge clk);
    check(regRdData[24] == 1'b1, "R4 sticky", regRdData[24], 1);
    wrCfg(mkCfg(1, 0, 1, 1, 0, 0));
    check(regRdData[24] == 1'b0, "R4 cleared", regRdData[24], 0);
    check(wakeReq == 1'b0, "R8 wake drops with flag", wakeReq, 0);

    // R5 clear write coincides with qualifying edge
    cmpRawIn = 1'b0;
    repeat (4) @(negedge clk);
    wrCfg(mkCfg(1, 0, 0, 0, 0, 0));
    cmpRawIn = 1'b1;
    @(negedge clk);
    @(negedge clk);
    regWrEn = 1'b1;
    regWrData = mkCfg(1, 0, 0, 0, 0, 0);
    @(negedge clk);
    regWrEn = 1'b0;
    check(regRdData[24] == 1'b1, "R5 edge beats clear", regRdData[24], 1);

    // R10 pass-through codes, all combinations
    for (int n = 0; n < 8; n++) begin
      for (int p = 0; p < 16; p++) begin
        for (int h = 0; h < 8; h++) begin
          logic [31:0] d;
          logic [31:0] expRd;
          d = 32'hFE00_0000 | (32'(n) << 12) | (32'(p) << 8) | (32'(h) << 5) | 32'h0008_0000;
          wrCfg(d);
          expRd = (32'(n) << 12) | (32'(p) << 8) | (32'(h) << 5) | (32'(cmpRawIn) << 20);
          check(negSel == n[2:0] && posSel == p[3:0] && hystSel == h[2:0],
                "R10 outputs", {negSel, posSel, hystSel}, {n[2:0], p[3:0], h[2:0]});
          check(regRdData == expRd, "R10 readback", regRdData, expRd);
        end
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule